// File: doc/BRIEF.md
# Bursty ON/OFF Cell Traffic Generator

This block is a slotted cell source for driving one input of a shared-bus switch model. It follows a two-state Markov chain that is either active or idle. While active, it sends one cell in every slot. Each cell carries the index of an output port. The ports a burst sends to are correlated. The first cell of a burst picks its port uniformly. Each later cell either stays on the burst's current port or moves to one of the other ports.

The slot rate comes from an external strobe, `slot_tick`. Three fixed-point thresholds set the behaviour: the chance to enter a burst, the chance to leave a burst, and the chance to keep the destination. They are worked out offline. For a mean burst length B and an offered load R, the leave threshold stands for 1/B and the enter threshold stands for R/(B(1-R)). Three free-running LFSRs supply the random draws, each with its own feedback polynomial. One decides state changes, one decides whether the destination is kept, and one chooses the port.

Top module: `burst_cell_source`

## Requirements
- R1: A synchronous reset leaves the source idle with `cell_valid` and `cell_dest` at 0. The first slot after reset therefore produces no cell, whatever the enter threshold is.
- R2: An idle source produces no cell. On a slot it becomes active when its state draw is below `enter_thr`. An `enter_thr` of 0 never starts a burst, and an all-ones `enter_thr` always starts one.
- R3: An active source produces exactly one cell per slot. `cell_valid` is high for the single clock cycle after the `slot_tick` cycle. The state change for a slot is decided after that slot's cell, so the slot that starts a burst carries no cell and the slot that ends one still carries its cell.
- R4: Clock cycles without `slot_tick` produce no cell and leave the source state unchanged, even if the thresholds change during them.
- R5: Every `cell_dest` is in 0..NUM_PORTS-1 while `cell_valid` is high, and `cell_dest` is 0 while `cell_valid` is low.
- R6: A cell after the first in a burst keeps the previous cell's port when the stick draw is below `stick_thr`. An all-ones `stick_thr` always keeps it.
- R7: A later cell that does not keep its port goes to a port different from the previous one. With `stick_thr` at 0, every later cell changes port.
- R8: The first-cell choice and the other-port choice both reach every legal port over a long run.
- R9: With `stick_thr` at half scale (0x8000 for 16 bits), the share of later cells that keep their port is close to one half.
- R10: A threshold t below all-ones gives a probability of t/2^THR_W. For example, with `enter_thr` all-ones and `leave_thr` at a quarter of full scale, about four slots in five carry a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_tick | input | 1 | One-cycle strobe marking a slot |
| enter_thr | input | THR_W | Idle-to-active threshold |
| leave_thr | input | THR_W | Active-to-idle threshold |
| stick_thr | input | THR_W | Keep-destination threshold |
| cell_valid | output | 1 | Cell emitted for the last slot |
| cell_dest | output | $clog2(NUM_PORTS) | Destination port of the cell |

## Verification
Every result of a slot arrives one register stage after the `slot_tick` edge, so the bench drives the strobe for one cycle at a falling edge and samples at the next falling edge. A state change made in a slot shows up only in the following slot, so the expected cell pattern is written slot by slot: no cell in the slot that starts a burst, then a cell in every slot after it. The random properties are checked as bounded counts over hundreds of slots, with thresholds at 0, half scale, quarter scale and all-ones.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   localparam int unsigned LFSR_W   = 32;
   localparam int unsigned N_DRAWS  = 3;
   localparam int unsigned DRAW_STATE = 0;
   localparam int unsigned DRAW_STICK = 1;
   localparam int unsigned DRAW_DEST  = 2;

   typedef enum logic {
      SRC_IDLE   = 1'b0,
      SRC_ACTIVE = 1'b1
   } src_state_e;

   function automatic logic [LFSR_W-1:0] poly_of(input int unsigned idx);
      case (idx)
         0:       return 32'h8020_0003;
         1:       return 32'hB4BC_D35C;
         default: return 32'h8000_0EA6;
      endcase
   endfunction

   function automatic logic [LFSR_W-1:0] seed_of(input int unsigned idx);
      case (idx)
         0:       return 32'h1F3A_9C5D;
         1:       return 32'h6B20_47E1;
         default: return 32'hC0DE_5A17;
      endcase
   endfunction

endpackage

// File: rtl/bcs_lfsr.sv
module bcs_lfsr #(
   parameter int unsigned               W     = 32,
   parameter logic [W-1:0]              POLY  = 32'h8020_0003,
   parameter logic [W-1:0]              SEED  = 32'h1,
   parameter int unsigned               STEPS = 16,
   parameter int unsigned               OUT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   output logic [OUT_W-1:0] draw
);

   if (OUT_W > W) begin : g_bad_width
      $error("bcs_lfsr: OUT_W exceeds W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("bcs_lfsr: zero seed locks up");
   end
   if (POLY[W-1] != 1'b1) begin : g_bad_poly
      $error("bcs_lfsr: feedback mask needs its top bit");
   end
   if (STEPS < 1) begin : g_bad_steps
      $error("bcs_lfsr: STEPS must be at least 1");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] state_d;

   always_comb begin
      state_d = state_q;
      for (int s = 0; s < int'(STEPS); s++) begin
         state_d = state_d[0] ? ((state_d >> 1) ^ POLY) : (state_d >> 1);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SEED;
      else     state_q <= state_d;
   end

   assign draw = state_q[W-1 -: OUT_W];

   // R10
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);

endmodule

// File: rtl/bcs_pick.sv
module bcs_pick #(
   parameter int unsigned RANGE  = 8,
   parameter bit          SKIP   = 1'b0,
   parameter int unsigned DRAW_W = 16,
   parameter int unsigned IW     = 3
) (
   input  logic [DRAW_W-1:0] draw,
   input  logic [IW-1:0]     skip_val,
   output logic [IW-1:0]     idx
);

   localparam int unsigned RB     = (RANGE > 1) ? $clog2(RANGE) : 1;
   localparam bit          IS_POW = (RANGE > 1) && ((1 << RB) == RANGE);
   localparam int unsigned PW     = DRAW_W + IW + 1;
   localparam int unsigned LIMIT  = SKIP ? RANGE + 1 : RANGE;

   if (RANGE < 1) begin : g_bad_range
      $error("bcs_pick: RANGE must be at least 1");
   end
   if (LIMIT > (1 << IW)) begin : g_bad_iw
      $error("bcs_pick: IW too narrow for RANGE");
   end
   if (RB > DRAW_W) begin : g_bad_draw
      $error("bcs_pick: draw narrower than range");
   end

   logic [IW-1:0] raw;

   if (RANGE == 1) begin : g_single
      assign raw = '0;
   end else if (IS_POW) begin : g_pow2
      assign raw = IW'(draw[DRAW_W-1 -: RB]);
   end else begin : g_scale
      logic [PW-1:0] prod;
      assign prod = PW'(draw) * PW'(RANGE);
      assign raw  = prod[DRAW_W +: IW];
   end

   if (SKIP) begin : g_skip
      assign idx = (raw >= skip_val) ? raw + IW'(1) : raw;
      // R7
      always_comb begin
         skip_differs_chk: assert (idx != skip_val || $isunknown(skip_val));
      end
   end else begin : g_plain
      assign idx = raw;
   end

   // R5
   always_comb begin
      idx_range_chk: assert ({1'b0, idx} < (IW+1)'(LIMIT) || $isunknown(draw));
   end

endmodule

// File: rtl/bcs_onoff.sv
module bcs_onoff
   import bcs_pkg::*;
#(
   parameter int unsigned THR_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             slot_tick,
   input  logic [THR_W-1:0] draw,
   input  logic [THR_W-1:0] enter_thr,
   input  logic [THR_W-1:0] leave_thr,
   output logic             active,
   output logic             fresh
);

   src_state_e state_q;
   logic       fresh_q;
   logic       enter_hit;
   logic       leave_hit;

   assign enter_hit = (&enter_thr) | (draw < enter_thr);
   assign leave_hit = (&leave_thr) | (draw < leave_thr);

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SRC_IDLE;
         fresh_q <= 1'b0;
      end else if (slot_tick) begin
         if (state_q == SRC_ACTIVE) begin
            fresh_q <= 1'b0;
            if (leave_hit) state_q <= SRC_IDLE;
         end else if (enter_hit) begin
            state_q <= SRC_ACTIVE;
            fresh_q <= 1'b1;
         end
      end
   end

   assign active = (state_q == SRC_ACTIVE);
   assign fresh  = fresh_q;

   // R2
   idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && !active && enter_thr == '0) |=> !active);

   // R2
   always_enter_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && !active && (&enter_thr)) |=> (active && fresh));

   // R4
   hold_state_chk: assert property (@(posedge clk) disable iff (rst)
      !slot_tick |=> ($stable(active) && $stable(fresh)));

endmodule

// File: rtl/burst_cell_source.sv
module burst_cell_source
   import bcs_pkg::*;
#(
   parameter  int unsigned NUM_PORTS  = 8,
   parameter  int unsigned THR_W      = 16,
   parameter  int unsigned LFSR_STEPS = 16,
   localparam int unsigned DEST_W     = (NUM_PORTS > 2) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              slot_tick,
   input  logic [THR_W-1:0]  enter_thr,
   input  logic [THR_W-1:0]  leave_thr,
   input  logic [THR_W-1:0]  stick_thr,
   output logic              cell_valid,
   output logic [DEST_W-1:0] cell_dest
);

   if (NUM_PORTS < 2) begin : g_bad_ports
      $error("burst_cell_source: need at least two ports");
   end
   if (THR_W < 2 || THR_W > LFSR_W) begin : g_bad_thr
      $error("burst_cell_source: THR_W out of range");
   end

   logic [THR_W-1:0] draws [N_DRAWS];

   for (genvar g = 0; g < int'(N_DRAWS); g++) begin : g_src
      bcs_lfsr #(
         .W     (LFSR_W),
         .POLY  (poly_of(g)),
         .SEED  (seed_of(g)),
         .STEPS (LFSR_STEPS),
         .OUT_W (THR_W)
      ) u_lfsr (
         .clk  (clk),
         .rst  (rst),
         .draw (draws[g])
      );
   end

   logic active;
   logic fresh;

   bcs_onoff #(.THR_W(THR_W)) u_onoff (
      .clk       (clk),
      .rst       (rst),
      .slot_tick (slot_tick),
      .draw      (draws[DRAW_STATE]),
      .enter_thr (enter_thr),
      .leave_thr (leave_thr),
      .active    (active),
      .fresh     (fresh)
   );

   logic [DEST_W-1:0] cur_dest;
   logic [DEST_W-1:0] first_idx;
   logic [DEST_W-1:0] other_idx;
   logic [DEST_W-1:0] next_dest;
   logic              keep_hit;

   bcs_pick #(
      .RANGE  (NUM_PORTS),
      .SKIP   (1'b0),
      .DRAW_W (THR_W),
      .IW     (DEST_W)
   ) u_first (
      .draw     (draws[DRAW_DEST]),
      .skip_val (cur_dest),
      .idx      (first_idx)
   );

   bcs_pick #(
      .RANGE  (NUM_PORTS - 1),
      .SKIP   (1'b1),
      .DRAW_W (THR_W),
      .IW     (DEST_W)
   ) u_other (
      .draw     (draws[DRAW_DEST]),
      .skip_val (cur_dest),
      .idx      (other_idx)
   );

   assign keep_hit = (&stick_thr) | (draws[DRAW_STICK] < stick_thr);

   always_comb begin
      if (fresh)         next_dest = first_idx;
      else if (keep_hit) next_dest = cur_dest;
      else               next_dest = other_idx;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cell_valid <= 1'b0;
         cell_dest  <= '0;
         cur_dest   <= '0;
      end else begin
         cell_valid <= slot_tick & active;
         if (slot_tick && active) begin
            cell_dest <= next_dest;
            cur_dest  <= next_dest;
         end else begin
            cell_dest <= '0;
         end
      end
   end

   // R3
   cell_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
      cell_valid |-> ($past(slot_tick) && $past(active)));

   // R5
   dest_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !cell_valid |-> (cell_dest == '0));

   // R5
   dest_legal_chk: assert property (@(posedge clk) disable iff (rst)
      cell_valid |-> (int'(cell_dest) < int'(NUM_PORTS)));

   // R6
   keep_all_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && active && !fresh && (&stick_thr)) |=> (cell_dest == $past(cur_dest)));

   // R7
   swap_all_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_tick && active && !fresh && stick_thr == '0) |=> (cell_dest != $past(cur_dest)));

endmodule

// File: tb/burst_cell_source_test.sv
module burst_cell_source_test;

   localparam int N  = 6;
   localparam int TW = 16;
   localparam int DW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          slot_tick = 1'b0;
   logic [TW-1:0] enter_thr = '0;
   logic [TW-1:0] leave_thr = '0;
   logic [TW-1:0] stick_thr = '0;
   logic          cell_valid;
   logic [DW-1:0] cell_dest;

   int n_checks = 0;
   int n_fails  = 0;

   always #10 clk = ~clk;

   burst_cell_source #(.NUM_PORTS(N), .THR_W(TW)) uut (
      .clk        (clk),
      .rst        (rst),
      .slot_tick  (slot_tick),
      .enter_thr  (enter_thr),
      .leave_thr  (leave_thr),
      .stick_thr  (stick_thr),
      .cell_valid (cell_valid),
      .cell_dest  (cell_dest)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk) slot_tick = 1'b1;
      @(negedge clk) slot_tick = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk) rst = 1'b1;
      @(negedge clk) rst = 1'b0;
   endtask

   task automatic t_reset();
      enter_thr = '1; leave_thr = '0; stick_thr = '0;
      do_reset();
      chk(cell_valid == 1'b0, "R1 valid after reset", int'(cell_valid), 0);
      chk(cell_dest == '0, "R1 dest after reset", int'(cell_dest), 0);
      tick();
      chk(cell_valid == 1'b0, "R1 first slot after reset", int'(cell_valid), 0);
   endtask

   task automatic t_idle_hold();
      int cells = 0;
      enter_thr = '0; leave_thr = '0;
      do_reset();
      for (int i = 0; i < 40; i++) begin
         tick();
         if (cell_valid) cells++;
      end
      chk(cells == 0, "R2 idle with zero enter threshold", cells, 0);
   endtask

   task automatic t_burst_keep();
      int cells = 0;
      int same = 0;
      int bad = 0;
      int first;
      enter_thr = '1; leave_thr = '0; stick_thr = '1;
      do_reset();
      tick();
      chk(cell_valid == 1'b0, "R3 starting slot has no cell", int'(cell_valid), 0);
      tick();
      first = int'(cell_dest);
      chk(cell_valid == 1'b1, "R3 first cell of burst", int'(cell_valid), 1);
      for (int i = 0; i < 30; i++) begin
         tick();
         if (cell_valid) cells++;
         if (int'(cell_dest) == first) same++;
         if (int'(cell_dest) >= N) bad++;
      end
      chk(cells == 30, "R3 one cell per active slot", cells, 30);
      chk(same == 30, "R6 full stick keeps port", same, 30);
      chk(bad == 0, "R5 dest in range", bad, 0);
      // R4: no strobe, thresholds changed meanwhile
      leave_thr = '1;
      repeat (2) @(negedge clk);
      chk(cell_valid == 1'b0 && cell_dest == '0, "R4 R5 quiet between slots", int'(cell_valid), 0);
      repeat (6) @(negedge clk);
      leave_thr = '0;
      tick();
      chk(cell_valid == 1'b1, "R4 state kept without strobe", int'(cell_valid), 1);
   endtask

   task automatic t_swap();
      int prev;
      int repeats = 0;
      int bad = 0;
      bit seen [N];
      int nseen = 0;
      foreach (seen[k]) seen[k] = 1'b0;
      enter_thr = '1; leave_thr = '0; stick_thr = '0;
      do_reset();
      tick();
      tick();
      prev = int'(cell_dest);
      for (int i = 0; i < 200; i++) begin
         tick();
         if (!cell_valid || int'(cell_dest) >= N) bad++;
         else seen[int'(cell_dest)] = 1'b1;
         if (int'(cell_dest) == prev) repeats++;
         prev = int'(cell_dest);
      end
      foreach (seen[k]) if (seen[k]) nseen++;
      chk(repeats == 0, "R7 zero stick always moves", repeats, 0);
      chk(bad == 0, "R5 R7 moved cells legal", bad, 0);
      chk(nseen == N, "R8 other-port pick covers ports", nseen, N);
   endtask

   task automatic t_alternate();
      int mism = 0;
      bit seen [N];
      int nseen = 0;
      foreach (seen[k]) seen[k] = 1'b0;
      enter_thr = '1; leave_thr = '1; stick_thr = '1;
      do_reset();
      for (int i = 0; i < 300; i++) begin
         tick();
         if (cell_valid != ((i % 2) == 1)) mism++;
         if (cell_valid && int'(cell_dest) < N) seen[int'(cell_dest)] = 1'b1;
      end
      foreach (seen[k]) if (seen[k]) nseen++;
      chk(mism == 0, "R3 one-cell bursts alternate", mism, 0);
      chk(nseen == N, "R8 first-cell pick covers ports", nseen, N);
   endtask

   task automatic t_keep_frac();
      int prev;
      int kept = 0;
      enter_thr = '1; leave_thr = '0; stick_thr = 16'h8000;
      do_reset();
      tick();
      tick();
      prev = int'(cell_dest);
      for (int i = 0; i < 400; i++) begin
         tick();
         if (int'(cell_dest) == prev) kept++;
         prev = int'(cell_dest);
      end
      chk(kept >= 140 && kept <= 260, "R9 half-scale keep share", kept, 200);
   endtask

   task automatic t_leave_frac();
      int cells = 0;
      enter_thr = '1; leave_thr = 16'h4000; stick_thr = '0;
      do_reset();
      for (int i = 0; i < 800; i++) begin
         tick();
         if (cell_valid) cells++;
      end
      chk(cells >= 560 && cells <= 720, "R10 quarter leave gives 4/5 load", cells, 640);
   endtask

   task automatic t_reset_mid();
      enter_thr = '1; leave_thr = '0; stick_thr = '0;
      do_reset();
      repeat (4) tick();
      chk(cell_valid == 1'b1, "R3 burst running before reset", int'(cell_valid), 1);
      enter_thr = '0;
      do_reset();
      tick();
      chk(cell_valid == 1'b0, "R1 reset ends burst", int'(cell_valid), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_idle_hold();
      t_burst_keep();
      t_swap();
      t_alternate();
      t_keep_frac();
      t_leave_frac();
      t_reset_mid();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule